// File: doc/BRIEF.md
# Sample Magnitude Threshold Detector

This block watches a stream of 14-bit two's-complement converter samples. A sample is taken on each clock where the valid input is high. For each accepted sample it forms a 13-bit magnitude and compares it with a programmable upper limit, a programmable lower limit and a coarse level picked by a 3-bit code. From these comparisons it produces four indications: a fine upper flag, a coarse upper flag, a lower flag and a request to raise gain.

The lower flag and the gain request are qualified by a dwell timer. They assert only once the magnitude has stayed under the lower limit for a programmed number of consecutive accepted samples. One sample at or above the limit clears them.

A 3-bit mode input selects what the four-bit flag output carries: either the four indications or the top bits of the latest magnitude. An enable input marks the output as driven or not driven. The block is meant to sit beside the data path of a receiver and give a gain-control loop an early warning of overload or of a weak signal.

Top module: `mag_threshold_detector`

## Requirements
- R1: The magnitude is |x| of the signed 14-bit input, held to 13 bits. The input 14'h2000 (−8192) gives 8191, and every other input gives exactly its absolute value.
- R2: The fine upper indication is 1 when the magnitude is strictly greater than the 13-bit upper limit, so a magnitude equal to the limit gives 0.
- R3: With coarse code c (0 to 7), the coarse indication is 1 when the magnitude is greater than or equal to 2^(12−c).
- R4: The lower indication and the gain request go to 1 only when the run of consecutive accepted samples below the lower limit, counting the current one, has reached the 16-bit dwell length. A dwell length of 0 behaves like 1. The run count saturates at 65535.
- R5: An accepted sample whose magnitude is at or above the lower limit resets the run to zero. The lower indication and the gain request read 0 after that same sample.
- R6: flags_out depends on mode_sel as follows. Mode 0 gives {coarse, fine upper, lower, gain request} on bits 3..0. Mode 1 gives magnitude bits 12..9. Mode 2 gives {fine upper, magnitude bits 12..10}. Mode 3 gives {fine upper, lower, magnitude bits 12..11}. Codes 4 to 7 act as mode 0. A change of mode shows on flags_out in the same cycle.
- R7: When det_enable is 0, flags_drive is 0 and flags_out is all zeros. When det_enable is 1, flags_drive is 1.
- R8: The indications and the stored magnitude update on the clock edge at which samp_valid is 1, one cycle after the sample is presented. On cycles with samp_valid at 0 they hold their values, and those cycles do not add to the run.
- R9: While rst_n is 0, all indications, the stored magnitude and the run count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_valid | input | 1 | Sample accepted on this edge |
| samp_data | input | 14 | Two's-complement sample |
| upper_thr | input | 13 | Fine upper limit |
| lower_thr | input | 13 | Lower limit |
| dwell_len | input | 16 | Required below-limit run length in samples |
| coarse_code | input | 3 | Coarse level select |
| mode_sel | input | 3 | Output content select |
| det_enable | input | 1 | Output enable |
| flags_out | output | 4 | Selected indications or magnitude bits |
| flags_drive | output | 1 | High when flags_out is to be driven |

## Verification
Every indication and every magnitude bit is due on the first clock edge after the valid sample. Mode and enable act combinationally on the registered state. The bench therefore drives each sample at a falling edge, lets one rising edge pass, and reads flags_out at the next falling edge, well clear of any edge. Changes of mode or enable are read one time unit after they are applied, with no edge in between. The run length is tracked in the bench's own model sample by sample, so the expected lower flag can be compared on exactly the sample where the dwell length is reached.

// File: rtl/mtd_pkg.sv
// Shared definitions for the magnitude threshold detector.
// Assumes a four-bit flag output and a 3-bit mode field.
package mtd_pkg;
    localparam int OUT_W  = 4;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_FLAGS      = 3'd0;
    localparam logic [MODE_W-1:0] MODE_MAG4       = 3'd1;
    localparam logic [MODE_W-1:0] MODE_UP_MAG3    = 3'd2;
    localparam logic [MODE_W-1:0] MODE_UP_LO_MAG2 = 3'd3;

    typedef struct packed {
        logic coarse;
        logic upper;
        logic lower;
        logic gain_up;
    } ind_t;
endpackage

// File: rtl/mtd_magnitude.sv
// Turns a two's-complement sample into an unsigned magnitude.
// Assumes MAG_W == SAMPLE_W - 1; the single out-of-range case
// (most negative input) saturates to all ones.
module mtd_magnitude #(
    parameter int SAMPLE_W = 14,
    parameter int MAG_W    = SAMPLE_W - 1
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic [MAG_W-1:0]    mag
);
    logic [SAMPLE_W-1:0] abs_v;

    // absolute value in full sample width
    always_comb begin
        abs_v = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
    end

    // clamp to the magnitude width
    always_comb begin
        mag = abs_v[SAMPLE_W-1] ? '1 : abs_v[MAG_W-1:0];
    end
endmodule

// File: rtl/mtd_upper_cmp.sv
// Combinational upper-side comparisons: fine limit (strictly greater)
// and a coarse power-of-two level picked by a code.
// Assumes 2**CODE_W <= MAG_W so every coarse level fits the magnitude.
module mtd_upper_cmp #(
    parameter int MAG_W  = 13,
    parameter int CODE_W = 3
) (
    input  logic [MAG_W-1:0]  mag,
    input  logic [MAG_W-1:0]  upper_thr,
    input  logic [CODE_W-1:0] coarse_code,
    output logic              fine_hi,
    output logic              coarse_hi
);
    localparam int NUM_CODES = 1 << CODE_W;

    logic [NUM_CODES-1:0] level_hit;

    genvar c;
    generate
        for (c = 0; c < NUM_CODES; c++) begin : g_level
            localparam int SH = MAG_W - 1 - c;
            localparam logic [MAG_W-1:0] LEVEL = MAG_W'(1) << SH;
            assign level_hit[c] = (mag >= LEVEL);
        end
    endgenerate

    // fine limit compare and coarse level selection
    always_comb begin
        fine_hi   = (mag > upper_thr);
        coarse_hi = level_hit[coarse_code];
    end
endmodule

// File: rtl/mtd_dwell_track.sv
// Counts consecutive accepted samples below the lower limit and raises
// the lower and gain-request flags once the run reaches the dwell length.
// Assumes flags and count change only on accepted samples.
module mtd_dwell_track #(
    parameter int MAG_W   = 13,
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [MAG_W-1:0]   mag,
    input  logic [MAG_W-1:0]   lower_thr,
    input  logic [DWELL_W-1:0] dwell_len,
    output logic               lower_q,
    output logic               gain_q,
    output logic [DWELL_W-1:0] run_cnt
);
    logic               below;
    logic [DWELL_W-1:0] run_next;
    logic               met;

    // next run length with saturation
    always_comb begin
        below    = (mag < lower_thr);
        run_next = below ? ((run_cnt == '1) ? run_cnt : run_cnt + 1'b1) : '0;
        met      = below && (run_next >= dwell_len);
    end

    // run counter and qualified flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            lower_q <= 1'b0;
            gain_q  <= 1'b0;
        end else if (valid) begin
            run_cnt <= run_next;
            lower_q <= met;
            gain_q  <= met;
        end
    end
endmodule

// File: rtl/mtd_out_select.sv
// Chooses the content of the flag output by mode and applies the enable.
// Assumes undefined mode codes fall back to the indication set.
module mtd_out_select
    import mtd_pkg::*;
#(
    parameter int MAG_W = 13
) (
    input  ind_t              ind,
    input  logic [MAG_W-1:0]  mag_q,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              enable,
    output logic [OUT_W-1:0]  flags_out,
    output logic              flags_drive
);
    logic [OUT_W-1:0] chosen;

    // mode multiplexer
    always_comb begin
        case (mode_sel)
            MODE_MAG4:       chosen = mag_q[MAG_W-1 -: OUT_W];
            MODE_UP_MAG3:    chosen = {ind.upper, mag_q[MAG_W-1 -: OUT_W-1]};
            MODE_UP_LO_MAG2: chosen = {ind.upper, ind.lower, mag_q[MAG_W-1 -: OUT_W-2]};
            default:         chosen = ind;
        endcase
    end

    // output qualification
    always_comb begin
        flags_drive = enable;
        flags_out   = enable ? chosen : '0;
    end
endmodule

// File: rtl/mag_threshold_detector.sv
// Top of the magnitude threshold detector: magnitude, upper compares,
// dwell-qualified lower side, and output selection. Registered indications
// update one cycle after each accepted sample.
module mag_threshold_detector
    import mtd_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int DWELL_W  = 16,
    parameter int CODE_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_valid,
    input  logic [13:0]         samp_data,
    input  logic [12:0]         upper_thr,
    input  logic [12:0]         lower_thr,
    input  logic [15:0]         dwell_len,
    input  logic [2:0]          coarse_code,
    input  logic [2:0]          mode_sel,
    input  logic                det_enable,
    output logic [3:0]          flags_out,
    output logic                flags_drive
);
    localparam int MAG_W = SAMPLE_W - 1;

    logic [MAG_W-1:0]   mag_w;
    logic [MAG_W-1:0]   mag_q;
    logic               fine_hi;
    logic               coarse_hi;
    logic               upper_q;
    logic               coarse_q;
    logic               lower_q;
    logic               gain_q;
    logic [DWELL_W-1:0] run_cnt;
    ind_t               ind;

    mtd_magnitude #(.SAMPLE_W(SAMPLE_W), .MAG_W(MAG_W)) u_mag (
        .sample (samp_data),
        .mag    (mag_w)
    );

    mtd_upper_cmp #(.MAG_W(MAG_W), .CODE_W(CODE_W)) u_upper (
        .mag         (mag_w),
        .upper_thr   (upper_thr),
        .coarse_code (coarse_code),
        .fine_hi     (fine_hi),
        .coarse_hi   (coarse_hi)
    );

    mtd_dwell_track #(.MAG_W(MAG_W), .DWELL_W(DWELL_W)) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (samp_valid),
        .mag       (mag_w),
        .lower_thr (lower_thr),
        .dwell_len (dwell_len),
        .lower_q   (lower_q),
        .gain_q    (gain_q),
        .run_cnt   (run_cnt)
    );

    // register upper-side indications and magnitude per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q  <= 1'b0;
            coarse_q <= 1'b0;
            mag_q    <= '0;
        end else if (samp_valid) begin
            upper_q  <= fine_hi;
            coarse_q <= coarse_hi;
            mag_q    <= mag_w;
        end
    end

    // bundle the indications for the selector
    always_comb begin
        ind.coarse  = coarse_q;
        ind.upper   = upper_q;
        ind.lower   = lower_q;
        ind.gain_up = gain_q;
    end

    mtd_out_select #(.MAG_W(MAG_W)) u_sel (
        .ind         (ind),
        .mag_q       (mag_q),
        .mode_sel    (mode_sel),
        .enable      (det_enable),
        .flags_out   (flags_out),
        .flags_drive (flags_drive)
    );
endmodule

// File: rtl/mtd_checker.sv
// Temporal checks on the detector, attached to every instance by bind.
module mtd_checker #(
    parameter int SAMPLE_W = 14,
    parameter int MAG_W    = 13,
    parameter int DWELL_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                samp_valid,
    input logic [SAMPLE_W-1:0] samp_data,
    input logic [MAG_W-1:0]    upper_thr,
    input logic [MAG_W-1:0]    lower_thr,
    input logic [DWELL_W-1:0]  dwell_len,
    input logic                det_enable,
    input logic [MAG_W-1:0]    mag_w,
    input logic                upper_q,
    input logic                coarse_q,
    input logic                lower_q,
    input logic                gain_q,
    input logic [DWELL_W-1:0]  run_cnt,
    input logic [3:0]          flags_out,
    input logic                flags_drive
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    AST_MAG_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        samp_data == MOST_NEG |-> mag_w == '1); // R1

    AST_UPPER_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> upper_q == ($past(mag_w) > $past(upper_thr))); // R2

    AST_DWELL_MET: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> (!lower_q || run_cnt >= $past(dwell_len))); // R4

    AST_LOWER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid && (mag_w >= lower_thr) |=> !lower_q && !gain_q && run_cnt == '0); // R5

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !det_enable |-> !flags_drive && flags_out == '0); // R7

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> $stable({upper_q, coarse_q, lower_q, gain_q, run_cnt})); // R8
endmodule

bind mag_threshold_detector mtd_checker #(
    .SAMPLE_W(SAMPLE_W), .MAG_W(MAG_W), .DWELL_W(DWELL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .samp_valid  (samp_valid),
    .samp_data   (samp_data),
    .upper_thr   (upper_thr),
    .lower_thr   (lower_thr),
    .dwell_len   (dwell_len),
    .det_enable  (det_enable),
    .mag_w       (mag_w),
    .upper_q     (upper_q),
    .coarse_q    (coarse_q),
    .lower_q     (lower_q),
    .gain_q      (gain_q),
    .run_cnt     (run_cnt),
    .flags_out   (flags_out),
    .flags_drive (flags_drive)
);

// File: tb/tb_mag_threshold_detector.sv
module tb_mag_threshold_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_valid = 1'b0;
    logic [13:0] samp_data = '0;
    logic [12:0] upper_thr = '0;
    logic [12:0] lower_thr = '0;
    logic [15:0] dwell_len = '0;
    logic [2:0]  coarse_code = '0;
    logic [2:0]  mode_sel = '0;
    logic        det_enable = 1'b1;
    logic [3:0]  flags_out;
    logic        flags_drive;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state
    int run_m = 0;
    int last_mag = 0;
    bit last_up = 0, last_co = 0, last_lf = 0;

    mag_threshold_detector dut (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
        .upper_thr(upper_thr), .lower_thr(lower_thr), .dwell_len(dwell_len),
        .coarse_code(coarse_code), .mode_sel(mode_sel), .det_enable(det_enable),
        .flags_out(flags_out), .flags_drive(flags_drive)
    );

    always #2 clk = ~clk;

    function automatic int mag_of(input logic [13:0] s);
        int v;
        v = int'($signed(s));
        if (v < 0) v = -v;
        if (v > 8191) v = 8191;
        return v;
    endfunction

    function automatic logic [3:0] expect_out();
        logic [3:0] r;
        case (mode_sel)
            3'd1:    r = 4'(last_mag >> 9);
            3'd2:    r = {last_up, 3'(last_mag >> 10)};
            3'd3:    r = {last_up, last_lf, 2'(last_mag >> 11)};
            default: r = {last_co, last_up, last_lf, last_lf};
        endcase
        return det_enable ? r : 4'd0;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: flags_out=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // drive one accepted sample at a falling edge, update model, wait for result
    task automatic send(input logic [13:0] s);
        int m;
        bit below;
        samp_data  = s;
        samp_valid = 1'b1;
        m = mag_of(s);
        below = (m < int'(lower_thr));
        if (below) run_m = (run_m < 65535) ? run_m + 1 : run_m;
        else run_m = 0;
        last_mag = m;
        last_up  = (m > int'(upper_thr));
        last_co  = (m >= (1 << (12 - int'(coarse_code))));
        last_lf  = below && (run_m >= int'(dwell_len));
        @(posedge clk);
        @(negedge clk);
        samp_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        run_m = 0; last_mag = 0; last_up = 0; last_co = 0; last_lf = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R9: reset state
        repeat (2) @(negedge clk);
        mode_sel = 3'd0;
        check("R9 reset flags", flags_out, 4'd0);
        mode_sel = 3'd1; #1;
        check("R9 reset magnitude", flags_out, 4'd0);
        mode_sel = 3'd0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5: full sweep in mode 0
        upper_thr = 13'd5000; lower_thr = 13'd1500; dwell_len = 16'd3;
        for (int i = 0; i < 16384; i++) begin
            coarse_code = 3'(i % 8);
            send(14'(i));
            check("R2/R3/R4/R5 sweep mode0", flags_out, expect_out());
        end

        // R1 R6: full sweep in mode 1 (top magnitude bits)
        mode_sel = 3'd1;
        for (int i = 0; i < 16384; i++) begin
            send(14'(i));
            check("R1 sweep mode1", flags_out, expect_out());
        end

        // R6: modes 2 and 3 on a strided sweep
        for (int i = 0; i < 16384; i += 5) begin
            mode_sel = 3'd2;
            send(14'(i));
            check("R6 mode2", flags_out, expect_out());
            mode_sel = 3'd3; #1;
            check("R6 mode3", flags_out, expect_out());
        end

        // R1: most negative input and its neighbour
        mode_sel = 3'd1;
        send(14'h2000);
        check("R1 most negative", flags_out, 4'hF);
        send(14'h2001);
        check("R1 -8191", flags_out, 4'hF);

        // R2: equality boundary
        mode_sel = 3'd0; upper_thr = 13'd1000; lower_thr = 13'd0; coarse_code = 3'd0;
        send(14'd1000);
        check("R2 equal is not above", flags_out, 4'b0000);
        send(14'd1001);
        check("R2 one above", flags_out, 4'b0100);

        // R3: every coarse level at and below its edge, both signs
        upper_thr = 13'h1FFF;
        for (int c = 0; c < 8; c++) begin
            coarse_code = 3'(c);
            send(14'((1 << (12 - c)) - 1));
            check("R3 below level", flags_out, expect_out());
            send(14'(-(1 << (12 - c))));
            check("R3 at level negative", flags_out, {1'b1, 3'b000});
        end

        // R4 R5 R8: dwell qualification
        do_reset();
        mode_sel = 3'd0; coarse_code = 3'd7; upper_thr = 13'h1FFF;
        lower_thr = 13'd100; dwell_len = 16'd5;
        for (int k = 1; k <= 4; k++) begin
            send(14'd50);
            check("R4 before dwell", flags_out, 4'b1000);
        end
        repeat (3) @(negedge clk);
        check("R8 idle cycles hold", flags_out, 4'b1000);
        send(14'd50);
        check("R4 dwell reached", flags_out, 4'b1011);
        repeat (4) @(negedge clk);
        check("R8 held through idle", flags_out, 4'b1011);
        send(-14'sd60);
        check("R4 stays below", flags_out, 4'b1011);
        send(14'd100);
        check("R5 equal to lower clears", flags_out, 4'b1000);
        send(14'd50);
        check("R5 run restarted", flags_out, 4'b1000);

        // R4: dwell lengths 0 and 1 act at once
        dwell_len = 16'd0;
        send(14'd200); send(14'd10);
        check("R4 dwell zero", flags_out, 4'b0011);
        dwell_len = 16'd1;
        send(14'd200); send(14'd10);
        check("R4 dwell one", flags_out, 4'b0011);

        // R9: reset in the middle clears a set lower flag
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset", flags_out, 4'b0000);
        rst_n = 1'b1; run_m = 0;
        dwell_len = 16'd2;
        send(14'd10);
        check("R9 run restarted after reset", flags_out, 4'b0000);
        send(14'd10);
        check("R4 after reset reached", flags_out, 4'b0011);

        // R6: fallback codes 4..7 equal mode 0
        for (int md = 4; md < 8; md++) begin
            mode_sel = 3'(md); #1;
            check("R6 fallback mode", flags_out, 4'b0011);
        end

        // R7: enable low blanks output and drive
        det_enable = 1'b0; #1;
        check("R7 disabled output", flags_out, 4'b0000);
        check_bit("R7 disabled drive", flags_drive, 1'b0);
        det_enable = 1'b1; mode_sel = 3'd0; #1;
        check("R7 re-enabled output", flags_out, 4'b0011);
        check_bit("R7 enabled drive", flags_drive, 1'b1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule